// File: doc/BRIEF.md
# Accumulator ALU with Zero Flag

This block computes the next value of an 8-bit accumulator from three byte sources: the accumulator itself, a general register that supplies the second operand of every two-operand operation, and an immediate byte. A 4-bit operation select picks the operation, and it is meant to be wired straight to the low nibble of an instruction opcode. The eight codes from 8 to F are arithmetic and logic operations. The codes from 0 to 7 pass the accumulator through unchanged.

The result is combinational, and a combinational zero indication is produced beside it. A one-bit zero flag register captures that indication on a clock edge. It does so only when the controller raises its flag-load enable and the select is one of the arithmetic or logic codes. Moves, loads and jumps therefore never disturb the flag, even if the enable is raised by mistake. No carry or overflow is kept. All arithmetic wraps modulo 2^DATA_W.

Top module: `acc_alu_zf`

## Requirements
- R1: Select 8 (add) gives result = (acc + reg) mod 256.
- R2: Select 9 (subtract) gives result = (acc - reg) mod 256, formed as acc plus the two's complement of reg.
- R3: Select A (increment) gives result = (acc + 1) mod 256, so 0xFF becomes 0x00.
- R4: Select B (load immediate) gives result = imm, regardless of acc and reg.
- R5: Selects C, D and E give the bitwise AND, OR and XOR of acc with reg.
- R6: Select F gives the bitwise complement of acc.
- R7: Selects 0 to 7 give result = acc.
- R8: zero_out is 1 in the same cycle as the result when all 8 result bits are 0, and 0 otherwise.
- R9: At a rising clock edge where flag_load is 1 and op_sel is 8 to F, z_flag takes the value zero_out had before that edge.
- R10: At an edge where flag_load is 0, or where op_sel is 0 to 7, z_flag keeps its value.
- R11: While rst_n is 0, z_flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the zero flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_load | input | 1 | Controller request to write the zero flag |
| op_sel | input | 4 | Operation select, the low opcode nibble |
| acc_in | input | 8 | Accumulator, the first operand |
| reg_in | input | 8 | General register, the second operand |
| imm_in | input | 8 | Immediate byte |
| result_out | output | 8 | Next accumulator value |
| zero_out | output | 1 | Result-is-zero indication, combinational |
| z_flag | output | 1 | Registered zero flag |

## Verification
Directed corner vectors come first. Operand pairs whose sum is exactly 256 and equal operands under subtract show that wraparound and the two's-complement form reach zero. An accumulator of 0xFF under increment shows the wrap on increment. A non-zero immediate with a zero accumulator shows that code B ignores acc. After these, a long run of pseudo-random selects, operands and flag-load values covers all sixteen codes. That run is compared every cycle against a behavioural model. It shows apart the codes that must leave the flag alone (below 8, or with the enable low) from those that must rewrite it. Runs of zero results mixed with non-zero results make any stuck or inverted flag visible.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'h8,
      OP_SUB  = 4'h9,
      OP_INC  = 4'hA,
      OP_IMM  = 4'hB,
      OP_AND  = 4'hC,
      OP_OR   = 4'hD,
      OP_XOR  = 4'hE,
      OP_NOT  = 4'hF
   } alu_op_e;

   // ALU-class codes have the top select bit set
   function automatic logic is_alu_class(input logic [OP_W-1:0] sel);
      return sel[OP_W-1];
   endfunction
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
   import acc_alu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit RIPPLE_CHAIN = 1'b1
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [OP_W-1:0]   sel,
   output logic [DATA_W-1:0] sum
);
   logic [DATA_W-1:0] b_eff;
   logic              cin;

   // operand conditioning: subtract inverts B and injects a carry
   always_comb begin
      b_eff = opb;
      cin   = 1'b0;
      case (sel)
         OP_SUB: begin
            b_eff = ~opb;
            cin   = 1'b1;
         end
         OP_INC: begin
            b_eff = '0;
            cin   = 1'b1;
         end
         default: begin
            b_eff = opb;
            cin   = 1'b0;
         end
      endcase
   end

   generate
      if (RIPPLE_CHAIN) begin : g_ripple
         logic [DATA_W:0] carry;
         assign carry[0] = cin;
         for (genvar k = 0; k < DATA_W; k++) begin : g_bit
            assign sum[k]     = opa[k] ^ b_eff[k] ^ carry[k];
            assign carry[k+1] = (opa[k] & b_eff[k]) | (carry[k] & (opa[k] ^ b_eff[k]));
         end
      end else begin : g_behav
         assign sum = opa + b_eff + {{(DATA_W-1){1'b0}}, cin};
      end
   endgenerate
endmodule

// File: rtl/acc_alu_bitwise.sv
module acc_alu_bitwise
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [OP_W-1:0]   sel,
   output logic [DATA_W-1:0] res
);
   always_comb begin
      case (sel)
         OP_AND:  res = opa & opb;
         OP_OR:   res = opa | opb;
         OP_XOR:  res = opa ^ opb;
         OP_NOT:  res = ~opa;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/acc_alu_zero_det.sv
module acc_alu_zero_det #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] val,
   output logic              is_zero
);
   localparam int LVLS = $clog2(DATA_W);
   localparam int PADW = 1 << LVLS;

   // OR-reduction tree over a power-of-two padded vector
   logic [PADW-1:0] lvl [LVLS+1];
   assign lvl[0] = {{(PADW-DATA_W){1'b0}}, val};

   generate
      for (genvar s = 0; s < LVLS; s++) begin : g_lvl
         localparam int NODES = PADW >> (s + 1);
         for (genvar n = 0; n < PADW; n++) begin : g_node
            if (n < NODES) begin : g_or
               assign lvl[s+1][n] = lvl[s][2*n] | lvl[s][2*n+1];
            end else begin : g_pad
               assign lvl[s+1][n] = 1'b0;
            end
         end
      end
   endgenerate

   assign is_zero = ~lvl[LVLS][0];
endmodule

// File: rtl/acc_alu_zf.sv
module acc_alu_zf
   import acc_alu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit RIPPLE_CHAIN = 1'b1,
   parameter bit Z_RESET_VAL  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flag_load,
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] reg_in,
   input  logic [DATA_W-1:0] imm_in,
   output logic [DATA_W-1:0] result_out,
   output logic              zero_out,
   output logic              z_flag
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("acc_alu_zf: DATA_W must be at least 2");
      end
      if (OP_W != 4) begin : g_bad_opw
         $error("acc_alu_zf: select width must be 4");
      end
   endgenerate

   logic [DATA_W-1:0] arith_res;
   logic [DATA_W-1:0] logic_res;
   logic              z_next;

   acc_alu_addsub #(.DATA_W(DATA_W), .RIPPLE_CHAIN(RIPPLE_CHAIN)) u_addsub (
      .opa (acc_in),
      .opb (reg_in),
      .sel (op_sel),
      .sum (arith_res)
   );

   acc_alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
      .opa (acc_in),
      .opb (reg_in),
      .sel (op_sel),
      .res (logic_res)
   );

   // final select: arithmetic group 8..A, immediate B, logic group C..F
   always_comb begin
      case (op_sel)
         OP_ADD, OP_SUB, OP_INC:         result_out = arith_res;
         OP_IMM:                         result_out = imm_in;
         OP_AND, OP_OR, OP_XOR, OP_NOT:  result_out = logic_res;
         default:                        result_out = acc_in;
      endcase
   end

   acc_alu_zero_det #(.DATA_W(DATA_W)) u_zdet (
      .val     (result_out),
      .is_zero (zero_out)
   );

   assign z_next = (flag_load && is_alu_class(op_sel)) ? zero_out : z_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) z_flag <= Z_RESET_VAL;
      else        z_flag <= z_next;
   end
endmodule

// File: rtl/acc_alu_zf_chk.sv
module acc_alu_zf_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flag_load,
   input logic [3:0]        op_sel,
   input logic [DATA_W-1:0] acc_in,
   input logic [DATA_W-1:0] reg_in,
   input logic [DATA_W-1:0] imm_in,
   input logic [DATA_W-1:0] result_out,
   input logic              zero_out,
   input logic              z_flag
);
   // R8
   zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_out == (result_out == '0));

   // R9
   z_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_load && op_sel[3]) |=> z_flag == $past(zero_out));

   // R10
   z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_load && op_sel[3]) |=> $stable(z_flag));

   // R4
   imm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 4'hB) |-> result_out == imm_in);

   // R6
   not_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 4'hF) |-> result_out == ~acc_in);

   // R7
   low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_sel[3] |-> result_out == acc_in);

   // R5
   xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 4'hE) |-> result_out == (acc_in ^ reg_in));

   // R3
   inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 4'hA && acc_in == '1) |-> result_out == '0);

   // R11
   always_comb begin
      if (!rst_n) begin
         reset_clear_chk: assert (z_flag == 1'b0);
      end
   end
endmodule

bind acc_alu_zf acc_alu_zf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_acc_alu_zf.sv
module tb_acc_alu_zf;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flag_load = 1'b0;
   logic [3:0] op_sel = 4'h0;
   logic [7:0] acc_in = 8'h00;
   logic [7:0] reg_in = 8'h00;
   logic [7:0] imm_in = 8'h00;
   logic [7:0] result_out;
   logic       zero_out;
   logic       z_flag;

   int checks = 0;
   int errors = 0;
   bit model_z = 1'b0;
   bit pend_z  = 1'b0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   acc_alu_zf dut (
      .clk(clk), .rst_n(rst_n), .flag_load(flag_load), .op_sel(op_sel),
      .acc_in(acc_in), .reg_in(reg_in), .imm_in(imm_in),
      .result_out(result_out), .zero_out(zero_out), .z_flag(z_flag)
   );

   function automatic int ref_result(int op, int a, int r, int i);
      case (op)
         8:  return (a + r) % 256;
         9:  return (a - r + 256) % 256;
         10: return (a + 1) % 256;
         11: return i;
         12: return a & r;
         13: return a | r;
         14: return a ^ r;
         15: return 255 - a;
         default: return a;
      endcase
   endfunction

   function automatic string req_of(int op);
      case (op)
         8: return "R1";
         9: return "R2";
         10: return "R3";
         11: return "R4";
         12, 13, 14: return "R5";
         15: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int op, input int a, input int r, input int i, input bit ld);
      int exp_res;
      bit exp_zero;
      @(posedge clk);
      #1;
      model_z = pend_z;
      // R9 / R10: flag after the edge
      check(z_flag == model_z, (ld ? "R9/R10" : "R10"), z_flag, model_z);
      op_sel    = 4'(op);
      acc_in    = 8'(a);
      reg_in    = 8'(r);
      imm_in    = 8'(i);
      flag_load = ld;
      #1;
      exp_res  = ref_result(op, a, r, i);
      exp_zero = (exp_res == 0);
      check(int'(result_out) == exp_res, req_of(op), result_out, exp_res);
      // R8
      check(zero_out == exp_zero, "R8", zero_out, exp_zero);
      pend_z = (ld && op >= 8) ? exp_zero : model_z;
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11
      check(z_flag == 1'b0, "R11", z_flag, 0);
      rst_n = 1'b1;
      model_z = 0;
      pend_z = 0;

      step(8, 8'h80, 8'h80, 0, 1);     // R1 wrap to zero, Z set
      step(8, 8'h12, 8'h34, 0, 1);     // R1 plain
      step(9, 8'h55, 8'h55, 0, 1);     // R2 equal -> zero
      step(9, 8'h00, 8'h01, 0, 1);     // R2 borrow wrap -> FF
      step(10, 8'hFF, 8'h00, 0, 1);    // R3 wrap to 0
      step(10, 8'h41, 8'h00, 0, 1);    // R3 plain
      step(11, 8'h00, 8'h00, 8'h5A, 1);// R4 imm with zero acc
      step(11, 8'h77, 8'h33, 8'h00, 1);// R4 zero imm
      step(12, 8'hF0, 8'h0F, 0, 1);    // R5 AND zero
      step(13, 8'hA0, 8'h05, 0, 1);    // R5 OR
      step(14, 8'h3C, 8'h3C, 0, 1);    // R5 XOR zero
      step(15, 8'hFF, 8'h00, 0, 1);    // R6 NOT -> zero
      step(15, 8'h0F, 8'h00, 0, 1);    // R6 NOT non-zero
      step(8, 8'h01, 8'hFF, 0, 1);     // R1 zero, Z set
      step(3, 8'h42, 8'h00, 0, 1);     // R7/R10 move code with load high: Z holds
      step(0, 8'h00, 8'h00, 0, 1);     // R7/R10 zero result, Z must not change
      step(14, 8'h01, 8'h00, 0, 0);    // R10 ALU code, load low: Z holds
      step(14, 8'h01, 8'h00, 0, 1);    // R9 clears Z
      step(7, 8'h00, 8'h00, 0, 1);     // R10 zero pass, Z stays 0
      step(4, 8'h99, 8'h11, 0, 0);     // R7

      for (int n = 0; n < 2000; n++) begin
         int op;
         op = $urandom_range(0, 15);
         step(op, $urandom_range(0, 3) == 0 ? 0 : $urandom_range(0, 255),
              $urandom_range(0, 255), $urandom_range(0, 3) == 0 ? 0 : $urandom_range(0, 255),
              bit'($urandom_range(0, 1)));
      end
      step(0, 0, 0, 0, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule